// File: doc/BRIEF.md
# Amplifier Configuration I2C Slave

This block is a small I2C target that receives amplifier configuration words. The system clock oversamples SCL and SDA. An already-encoded 2-bit strap picks one of three fixed 7-bit bus addresses. The fourth strap code turns the bus interface off and selects legacy mode. In legacy mode the three configuration outputs read as zero.

A write transaction carries three configuration bytes. They are applied to the outputs together, and only after all three have been acknowledged. A read transaction returns the byte presented on the diagnostic input. When a read transaction ends, the block issues a one-cycle clear strobe so the external diagnostic latches can reset. SDA is open-drain: the block only ever pulls the line low.

Top module: `amp_cfg_i2c_slave`

## Requirements
- R1: After reset, all three configuration outputs are 0x00, `sda_oe_o` is 0 and `diag_clr_o` is 0.
- R2: With `strap_i` = 2'b00, the block acknowledges the address byte of 7-bit address 1101100.
- R3: With `strap_i` = 2'b01 the address is 1101101, and with 2'b10 it is 1101111. Any address other than the selected one receives no acknowledge.
- R4: With `strap_i` = 2'b11 (legacy), the block never drives SDA and all three configuration outputs read 0x00.
- R5: In a write (R/W bit 0), the first, second and third data bytes go to `cfg0_o`, `cfg1_o` and `cfg2_o` in that order, and each byte is acknowledged.
- R6: The configuration outputs change only when the third byte's acknowledge completes. A write that stops earlier leaves all three outputs unchanged.
- R7: A data byte after the third is not acknowledged, and it changes no output.
- R8: In a read (R/W bit 1), each byte returns `diag_i` MSB first. A master acknowledge requests another byte, and a master not-acknowledge ends the data phase.
- R9: `diag_clr_o` pulses high for exactly one clock at the STOP or repeated START that ends a read transaction. It does not pulse for write transactions.
- R10: The SDA drive `sda_oe_o` changes only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line, as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Encoded address strap: 00, 01, 10 select an address, 11 selects legacy |
| diag_i | input | 8 | Diagnostic byte returned by reads |
| diag_clr_o | output | 1 | One-cycle clear strobe at the end of a read |
| cfg0_o | output | 8 | First configuration byte |
| cfg1_o | output | 8 | Second configuration byte |
| cfg2_o | output | 8 | Third configuration byte |

## Verification
Two events can land close together in the same cycle of handling:
- The STOP (or repeated START) that ends a transaction.
- The commit of the third byte, or the read-end clear strobe.

The bench provokes the first case by issuing STOP directly after the third byte's acknowledge. It then checks that the new bytes were still applied. For the second case, every read is closed with STOP, and the bench checks that each closing STOP adds exactly one strobe to a count of strobes, while write transactions leave that count unchanged.

// File: rtl/amp_cfg_pkg.sv
package amp_cfg_pkg;
  localparam int unsigned NUM_IB = 3;
  localparam int unsigned DW     = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } slv_state_e;

  localparam logic [1:0] STRAP_LEGACY = 2'b11;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_pipe[STAGES-1] & ~scl_q;
  assign scl_fall_o = ~scl_pipe[STAGES-1] & scl_q;
  // edges of SDA while SCL stays high
  assign start_o = scl_pipe[STAGES-1] & scl_q & sda_q & ~sda_pipe[STAGES-1];
  assign stop_o  = scl_pipe[STAGES-1] & scl_q & ~sda_q & sda_pipe[STAGES-1];
endmodule

// File: rtl/amp_cfg_addr_sel.sv
module amp_cfg_addr_sel (
  input  logic [1:0] strap_i,
  output logic [6:0] addr_o,
  output logic       legacy_o
);
  always_comb begin
    unique case (strap_i)
      2'b00:   addr_o = 7'b1101100;
      2'b01:   addr_o = 7'b1101101;
      2'b10:   addr_o = 7'b1101111;
      default: addr_o = 7'b0000000;
    endcase
  end
  assign legacy_o = (strap_i == amp_cfg_pkg::STRAP_LEGACY);
endmodule

// File: rtl/i2c_instr_fsm.sv
module i2c_instr_fsm
  import amp_cfg_pkg::*;
#(
  parameter int unsigned NB = NUM_IB,
  parameter int unsigned W  = DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sda_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [6:0]      addr_i,
  input  logic            enable_i,
  input  logic [W-1:0]    rd_data_i,
  output logic            sda_oe_o,
  output logic            commit_o,
  output logic [NB*W-1:0] wr_bytes_o,
  output logic            clr_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned IW = $clog2(NB + 1);
  localparam logic [CW-1:0] BITS_FULL = CW'(W);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NB - 1);
  localparam logic [IW-1:0] NB_L      = IW'(NB);

  slv_state_e     state;
  logic [CW-1:0]  bit_cnt;
  logic [IW-1:0]  byte_idx;
  logic [W-1:0]   sh, rd_sh;
  logic           rw, rd_active, mst_nack;
  logic [W-1:0]   buf_q [NB];

  wire match = enable_i && (sh[W-1:1] == addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      sh        <= '0;
      rd_sh     <= '0;
      rw        <= 1'b0;
      rd_active <= 1'b0;
      mst_nack  <= 1'b0;
      sda_oe_o  <= 1'b0;
      commit_o  <= 1'b0;
      clr_o     <= 1'b0;
      for (int i = 0; i < NB; i++) buf_q[i] <= '0;
    end else begin
      commit_o <= 1'b0;
      clr_o    <= 1'b0;
      if (start_i || stop_i) begin
        state    <= start_i ? ST_ADDR : ST_IDLE;
        bit_cnt  <= '0;
        byte_idx <= '0;
        sda_oe_o <= 1'b0;
        if (rd_active) begin
          clr_o     <= 1'b1;
          rd_active <= 1'b0;
        end
      end else if (scl_rise_i) begin
        case (state)
          ST_ADDR, ST_WR: begin
            sh      <= {sh[W-2:0], sda_i};
            bit_cnt <= bit_cnt + 1'b1;
          end
          ST_RD:     bit_cnt  <= bit_cnt + 1'b1;
          ST_RD_ACK: mst_nack <= sda_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (state)
          ST_ADDR: if (bit_cnt == BITS_FULL) begin
            if (match) begin
              sda_oe_o <= 1'b1;
              rw       <= sh[0];
              state    <= ST_ADDR_ACK;
            end else state <= ST_IDLE;
          end
          ST_ADDR_ACK: begin
            bit_cnt <= '0;
            if (rw) begin
              state     <= ST_RD;
              rd_sh     <= rd_data_i;
              sda_oe_o  <= ~rd_data_i[W-1];
              rd_active <= 1'b1;
            end else begin
              state    <= ST_WR;
              sda_oe_o <= 1'b0;
            end
          end
          ST_WR: if (bit_cnt == BITS_FULL) begin
            if (byte_idx < NB_L) begin
              buf_q[byte_idx] <= sh;
              sda_oe_o        <= 1'b1;
              state           <= ST_WR_ACK;
            end else state <= ST_IDLE;  // surplus byte: no ACK
          end
          ST_WR_ACK: begin
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_WR;
            byte_idx <= byte_idx + 1'b1;
            if (byte_idx == LAST_IDX) commit_o <= 1'b1;
          end
          ST_RD: if (bit_cnt == BITS_FULL) begin
            sda_oe_o <= 1'b0;
            state    <= ST_RD_ACK;
          end else begin
            rd_sh    <= rd_sh << 1;
            sda_oe_o <= ~rd_sh[W-2];
          end
          ST_RD_ACK: if (mst_nack) state <= ST_IDLE;
          else begin
            rd_sh    <= rd_data_i;
            sda_oe_o <= ~rd_data_i[W-1];
            bit_cnt  <= '0;
            state    <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_out
    assign wr_bytes_o[g*W +: W] = buf_q[g];
  end

  a_r9_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);
  a_r9_clr_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> $past(start_i || stop_i));
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i));
  a_r6_commit_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(state == ST_WR_ACK));
endmodule

// File: rtl/amp_cfg_i2c_slave.sv
module amp_cfg_i2c_slave
  import amp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [1:0] strap_i,
  input  logic [7:0] diag_i,
  output logic       diag_clr_o,
  output logic [7:0] cfg0_o,
  output logic [7:0] cfg1_o,
  output logic [7:0] cfg2_o
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic [6:0] addr;
  logic legacy, commit;
  logic [NUM_IB*DW-1:0] wr_bytes, cfg_q, cfg_vis;

  i2c_line_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  amp_cfg_addr_sel u_addr (.strap_i, .addr_o(addr), .legacy_o(legacy));

  i2c_instr_fsm #(.NB(NUM_IB), .W(DW)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .addr_i(addr), .enable_i(!legacy),
    .rd_data_i(diag_i), .sda_oe_o, .commit_o(commit), .wr_bytes_o(wr_bytes),
    .clr_o(diag_clr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (commit) cfg_q <= wr_bytes;
  end

  for (genvar g = 0; g < NUM_IB; g++) begin : g_mask
    assign cfg_vis[g*DW +: DW] = legacy ? '0 : cfg_q[g*DW +: DW];
  end

  assign cfg0_o = cfg_vis[0*DW +: DW];
  assign cfg1_o = cfg_vis[1*DW +: DW];
  assign cfg2_o = cfg_vis[2*DW +: DW];

  a_r4_legacy_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy |-> !sda_oe_o);
  a_r6_hold_without_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(cfg_q));
endmodule

// File: tb/amp_cfg_i2c_slave_bench.sv
module amp_cfg_i2c_slave_bench;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b00;
  logic [7:0] diag = 8'h00;
  logic sda_oe, diag_clr;
  logic [7:0] cfg0, cfg1, cfg2;
  wire line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  amp_cfg_i2c_slave u_amp_cfg_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(line), .sda_oe_o(sda_oe),
    .strap_i(strap), .diag_i(diag), .diag_clr_o(diag_clr),
    .cfg0_o(cfg0), .cfg1_o(cfg1), .cfg2_o(cfg2)
  );

  int n_chk = 0, n_fail = 0, clr_cnt = 0, viol = 0, obs_acks = 0;
  logic [7:0] obs_rd = '0;
  logic prev_oe = 1'b0;
  bit done = 0;

  always @(posedge clk) begin
    if (diag_clr) clr_cnt++;
    if (scl && (sda_oe !== prev_oe)) viol++;
    prev_oe <= sda_oe;
  end

  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t q[$];

  function automatic void expect_item(string r, int s, logic [31:0] e);
    item_t it;
    it.req = r; it.sel = s; it.exp = e;
    q.push_back(it);
  endfunction

  function automatic logic [31:0] probe(int s);
    case (s)
      0: return 32'(cfg0);
      1: return 32'(cfg1);
      2: return 32'(cfg2);
      3: return 32'(obs_acks);
      4: return 32'(obs_rd);
      5: return 32'(clr_cnt);
      6: return 32'(viol);
      default: return 32'(sda_oe);
    endcase
  endfunction

  // monitor: pop and compare away from the clock edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = probe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1; wq();
    sda_m = 1'b1; wq(); wq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; wq();
    scl = 1'b1; wq();
    r = line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
    bus_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic wr(input logic [6:0] a, input int n, input logic [31:0] d);
    logic ak;
    obs_acks = 0;
    bus_start();
    send_byte({a, 1'b0}, ak);
    if (ak) obs_acks++;
    for (int k = 0; k < n; k++) begin
      send_byte(d[31-8*k -: 8], ak);
      if (ak) obs_acks++;
    end
    bus_stop();
  endtask

  task automatic rd(input logic [6:0] a, input int n);
    logic ak, r;
    logic [7:0] v;
    obs_acks = 0;
    bus_start();
    send_byte({a, 1'b1}, ak);
    if (ak) obs_acks++;
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, r); v[i] = r; end
      bus_bit((k == n - 1), r);
      obs_rd = v;
    end
    bus_stop();
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_item("R1 cfg0", 0, 0); expect_item("R1 cfg1", 1, 0);
    expect_item("R1 cfg2", 2, 0); expect_item("R1 sda_oe", 7, 0);
    expect_item("R1 clr", 5, 0);
    settle();

    // R2/R5: full write, STOP right after third ACK
    wr(7'b1101100, 3, 32'hA1B2C300);
    expect_item("R2 R5 acks", 3, 4);
    expect_item("R5 cfg0", 0, 8'hA1); expect_item("R5 cfg1", 1, 8'hB2);
    expect_item("R5 cfg2", 2, 8'hC3); expect_item("R9 no clr on write", 5, 0);
    settle();

    // R6: truncated write
    wr(7'b1101100, 2, 32'h11220000);
    expect_item("R6 acks", 3, 3);
    expect_item("R6 cfg0 held", 0, 8'hA1); expect_item("R6 cfg1 held", 1, 8'hB2);
    settle();

    // R7: surplus byte
    wr(7'b1101100, 4, 32'h10203040);
    expect_item("R7 acks", 3, 4);
    expect_item("R7 cfg0", 0, 8'h10); expect_item("R7 cfg2", 2, 8'h30);
    settle();

    // R3: wrong address under strap 00
    wr(7'b1101101, 3, 32'hDEADBE00);
    expect_item("R3 nack", 3, 0); expect_item("R3 cfg kept", 0, 8'h10);
    settle();

    // R8/R9: reads
    diag = 8'h5A;
    rd(7'b1101100, 2);
    expect_item("R8 addr ack", 3, 1); expect_item("R8 data", 4, 8'h5A);
    expect_item("R9 clr count", 5, 1);
    settle();
    diag = 8'hC3;
    rd(7'b1101100, 1);
    expect_item("R8 data2", 4, 8'hC3); expect_item("R9 clr count2", 5, 2);
    settle();

    // R3: other strap codes
    strap = 2'b01;
    wr(7'b1101101, 3, 32'h01020300);
    expect_item("R3 strap01 acks", 3, 4); expect_item("R3 strap01 cfg1", 1, 8'h02);
    settle();
    strap = 2'b10;
    wr(7'b1101111, 3, 32'h0A0B0C00);
    expect_item("R3 strap10 acks", 3, 4); expect_item("R3 strap10 cfg2", 2, 8'h0C);
    settle();
    wr(7'b1101100, 3, 32'hFFFFFF00);
    expect_item("R3 old addr nack", 3, 0); expect_item("R3 cfg0 kept", 0, 8'h0A);
    settle();

    // R4: legacy
    strap = 2'b11;
    settle();
    expect_item("R4 cfg0", 0, 0); expect_item("R4 cfg1", 1, 0);
    expect_item("R4 cfg2", 2, 0);
    settle();
    wr(7'b1101111, 3, 32'h55555500);
    expect_item("R4 write nack", 3, 0);
    settle();
    rd(7'b1101100, 1);
    expect_item("R4 read nack", 3, 0); expect_item("R4 no clr", 5, 2);
    expect_item("R4 cfg0 after", 0, 0);
    settle();

    expect_item("R10 drive only scl low", 6, 0);
    settle(); settle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule